// File: doc/BRIEF.md
# Eviction-aware request gating controller

This block lives in a coherent request node. It keeps a small, fully associative table of cache lines being written back to the home node by a copyback eviction. While a line's eviction is in flight, the block refuses every new request that targets the same address. There is no exception by opcode, so a write-unique to the line is refused as well.

Each table entry passes through four phases:

- idle;
- eviction request sent, waiting for the home's completion that carries a data buffer ID;
- pending copyback, where the line is still held Unique Dirty but its data has not yet left;
- invalid-done, which lasts one cycle before the entry returns to idle.

The completion response moves an entry into the explicit pending-copyback phase rather than straight to invalid. Only the indication that the copyback data has been fully sent lets the line become invalid.

The cache side offers an eviction with a valid/ready handshake. Each accepted eviction is launched one cycle later as an outgoing request, tagged with its entry index as transaction ID. Home completions and copyback-sent indications name that same ID. New requests are checked against every live entry within the same cycle. A granted request is passed straight through to the outgoing port. A completion that names no entry waiting for one sets a sticky protocol-error flag.

Top module: `evict_gate_ctrl`

## Requirements
- R1: After reset, `ev_start_ready` is 1, `proto_err` is 0, `ev_req_valid` and `cb_launch_valid` are 0, and any new request is granted.
- R2: An eviction offered while `ev_start_ready` is 1 is accepted at that clock edge. In the following cycle, `ev_req_valid` is 1 for exactly one cycle, carrying the offered address and, as `ev_req_id`, the lowest-numbered entry that was idle.
- R3: When all NUM_ENTRIES entries are non-idle, `ev_start_ready` is 0. An eviction offered in that state is not accepted and produces no `ev_req_valid` pulse.
- R4: From the cycle after acceptance, a new request whose address equals a tracked line has `nreq_grant` 0 and `out_valid` 0.
- R5: A completion (`comp_valid`) whose `comp_id` names an entry waiting for its completion moves that entry to pending copyback. In the next cycle, `cb_launch_valid` pulses once with `cb_launch_id` equal to `comp_id` and `cb_launch_dbid` equal to `comp_dbid`.
- R6: While an entry is pending copyback, requests to its line are refused whatever the opcode, including write-unique.
- R7: A copyback-sent indication (`cb_sent_valid`, `cb_sent_id`) for a pending entry makes the line invalid. The request is still refused in the cycle right after that edge and is granted from the cycle after that.
- R8: A new request that matches no tracked line is granted in the same cycle, with `out_valid` 1 and `out_addr` and `out_opcode` equal to the request's address and opcode.
- R9: A completion whose ID names no entry waiting for a completion sets `proto_err`. The flag stays 1 until reset, and no copyback launch follows.
- R10: A copyback-sent indication for an entry that is not pending copyback has no effect: the line stays blocked, and a later valid completion for it still launches copyback.
- R11: An entry that has returned to idle is reused. `ev_start_ready` goes back to 1, and the next accepted eviction takes the lowest free index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start_valid | input | 1 | Eviction offered by the cache |
| ev_start_addr | input | ADDR_W | Line address of the eviction |
| ev_start_ready | output | 1 | A free entry exists |
| ev_req_valid | output | 1 | Outgoing eviction request pulse |
| ev_req_addr | output | ADDR_W | Address of the outgoing eviction |
| ev_req_id | output | ID_W | Transaction ID (entry index) |
| comp_valid | input | 1 | Completion with buffer ID from home |
| comp_id | input | ID_W | Transaction ID of the completion |
| comp_dbid | input | DBID_W | Data buffer ID given by home |
| cb_launch_valid | output | 1 | Copyback data launch pulse |
| cb_launch_id | output | ID_W | Entry whose data is launched |
| cb_launch_dbid | output | DBID_W | Buffer ID to write the data to |
| cb_sent_valid | input | 1 | Copyback data fully sent |
| cb_sent_id | input | ID_W | Entry whose data has been sent |
| nreq_valid | input | 1 | New request offered |
| nreq_addr | input | ADDR_W | New request address |
| nreq_opcode | input | OPC_W | New request opcode |
| nreq_grant | output | 1 | New request allowed this cycle |
| out_valid | output | 1 | Granted request forwarded |
| out_addr | output | ADDR_W | Forwarded address |
| out_opcode | output | OPC_W | Forwarded opcode |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The bound checker watches several properties on every cycle:

- each eviction pulse follows an accepted offer, and nothing is accepted while the block is not ready;
- each copyback launch follows a completion carrying the same ID;
- a just-accepted line is never granted;
- a line whose copyback was launched is refused in that cycle;
- the error flag never clears once set.

Some behaviour can only be shown by the bench's scenarios:

- the lowest-free-index choice and reuse after freeing;
- the exact one-cycle invalid-done window before a grant returns;
- refusal in the pending phase across several opcodes;
- a stray copyback-sent indication being ignored.

// File: rtl/evg_pkg.sv
package evg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_EVICT_SENT = 2'd1,
        ST_PEND_CB    = 2'd2,
        ST_INV_DONE   = 2'd3
    } trk_state_e;

endpackage

// File: rtl/evg_entry.sv
module evg_entry
    import evg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DBID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [ADDR_W-1:0] alloc_addr_i,
    input  logic              comp_i,
    input  logic [DBID_W-1:0] comp_dbid_i,
    input  logic              sent_i,
    output trk_state_e        state_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DBID_W-1:0] dbid_o,
    output logic              busy_o
);

    typedef struct packed {
        trk_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DBID_W-1:0] dbid;
    } ent_t;

    ent_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        unique case (ent_q.st)
            ST_IDLE: begin
                if (alloc_i) begin
                    ent_d.st   = ST_EVICT_SENT;
                    ent_d.addr = alloc_addr_i;
                end
            end
            ST_EVICT_SENT: begin
                // line still Unique Dirty, waiting for buffer ID
                if (comp_i) begin
                    ent_d.st   = ST_PEND_CB;
                    ent_d.dbid = comp_dbid_i;
                end
            end
            ST_PEND_CB: begin
                // data not yet gone: line must stay blocked
                if (sent_i) begin
                    ent_d.st = ST_INV_DONE;
                end
            end
            ST_INV_DONE: begin
                ent_d.st = ST_IDLE;
            end
            default: ent_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '{st: ST_IDLE, addr: '0, dbid: '0};
        end else begin
            ent_q <= ent_d;
        end
    end

    assign state_o = ent_q.st;
    assign addr_o  = ent_q.addr;
    assign dbid_o  = ent_q.dbid;
    assign busy_o  = (ent_q.st != ST_IDLE);

endmodule

// File: rtl/evg_alloc.sv
module evg_alloc #(
    parameter int NUM_ENTRIES = 4,
    parameter int ID_W        = 2
) (
    input  logic [NUM_ENTRIES-1:0] busy_i,
    output logic                   any_free_o,
    output logic [ID_W-1:0]        pick_o
);

    always_comb begin
        pick_o = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                pick_o = ID_W'(i);
            end
        end
    end

    assign any_free_o = ~&busy_i;

endmodule

// File: rtl/evg_match.sv
module evg_match #(
    parameter int NUM_ENTRIES = 4,
    parameter int ADDR_W      = 32
) (
    input  logic [NUM_ENTRIES-1:0]             busy_i,
    input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] tags_i,
    input  logic [ADDR_W-1:0]                  req_addr_i,
    output logic                               hit_o
);

    logic [NUM_ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = busy_i[g] && (tags_i[g] == req_addr_i);
    end

    assign hit_o = |hit_vec;

endmodule

// File: rtl/evict_gate_ctrl.sv
module evict_gate_ctrl
    import evg_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int ADDR_W      = 32,
    parameter int DBID_W      = 8,
    parameter int OPC_W       = 6,
    parameter int ID_W        = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start_valid,
    input  logic [ADDR_W-1:0] ev_start_addr,
    output logic              ev_start_ready,
    output logic              ev_req_valid,
    output logic [ADDR_W-1:0] ev_req_addr,
    output logic [ID_W-1:0]   ev_req_id,
    input  logic              comp_valid,
    input  logic [ID_W-1:0]   comp_id,
    input  logic [DBID_W-1:0] comp_dbid,
    output logic              cb_launch_valid,
    output logic [ID_W-1:0]   cb_launch_id,
    output logic [DBID_W-1:0] cb_launch_dbid,
    input  logic              cb_sent_valid,
    input  logic [ID_W-1:0]   cb_sent_id,
    input  logic              nreq_valid,
    input  logic [ADDR_W-1:0] nreq_addr,
    input  logic [OPC_W-1:0]  nreq_opcode,
    output logic              nreq_grant,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [OPC_W-1:0]  out_opcode,
    output logic              proto_err
);

    typedef struct packed {
        logic              ev_vld;
        logic [ADDR_W-1:0] ev_addr;
        logic [ID_W-1:0]   ev_id;
        logic              cb_vld;
        logic [ID_W-1:0]   cb_id;
        logic [DBID_W-1:0] cb_dbid;
        logic              err;
    } top_t;

    top_t r_d, r_q;

    trk_state_e                        ent_st   [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] ent_addr;
    logic [NUM_ENTRIES-1:0][DBID_W-1:0] ent_dbid;
    logic [NUM_ENTRIES-1:0]            ent_busy;
    logic [NUM_ENTRIES-1:0]            alloc_vec;
    logic [NUM_ENTRIES-1:0]            comp_hit;
    logic [NUM_ENTRIES-1:0]            sent_hit;

    logic            any_free;
    logic [ID_W-1:0] pick_id;
    logic            accept;
    logic            comp_ok;
    logic            addr_hit;

    evg_alloc #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ID_W        (ID_W)
    ) alloc_i (
        .busy_i     (ent_busy),
        .any_free_o (any_free),
        .pick_o     (pick_id)
    );

    assign accept = ev_start_valid && any_free;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        assign alloc_vec[g] = accept && (pick_id == ID_W'(g));
        assign comp_hit[g]  = comp_valid && (comp_id == ID_W'(g))
                              && (ent_st[g] == ST_EVICT_SENT);
        assign sent_hit[g]  = cb_sent_valid && (cb_sent_id == ID_W'(g));

        evg_entry #(
            .ADDR_W (ADDR_W),
            .DBID_W (DBID_W)
        ) entry_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc_i      (alloc_vec[g]),
            .alloc_addr_i (ev_start_addr),
            .comp_i       (comp_hit[g]),
            .comp_dbid_i  (comp_dbid),
            .sent_i       (sent_hit[g]),
            .state_o      (ent_st[g]),
            .addr_o       (ent_addr[g]),
            .dbid_o       (ent_dbid[g]),
            .busy_o       (ent_busy[g])
        );
    end

    assign comp_ok = |comp_hit;

    evg_match #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ADDR_W      (ADDR_W)
    ) match_i (
        .busy_i     (ent_busy),
        .tags_i     (ent_addr),
        .req_addr_i (nreq_addr),
        .hit_o      (addr_hit)
    );

    always_comb begin
        r_d         = r_q;
        r_d.ev_vld  = accept;
        r_d.ev_addr = accept ? ev_start_addr : r_q.ev_addr;
        r_d.ev_id   = accept ? pick_id : r_q.ev_id;
        r_d.cb_vld  = comp_ok;
        r_d.cb_id   = comp_ok ? comp_id : r_q.cb_id;
        r_d.cb_dbid = comp_ok ? comp_dbid : r_q.cb_dbid;
        r_d.err     = r_q.err || (comp_valid && !comp_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ev_start_ready  = any_free;
    assign ev_req_valid    = r_q.ev_vld;
    assign ev_req_addr     = r_q.ev_addr;
    assign ev_req_id       = r_q.ev_id;
    assign cb_launch_valid = r_q.cb_vld;
    assign cb_launch_id    = r_q.cb_id;
    assign cb_launch_dbid  = r_q.cb_dbid;
    assign proto_err       = r_q.err;

    assign nreq_grant = nreq_valid && !addr_hit;
    assign out_valid  = nreq_grant;
    assign out_addr   = nreq_addr;
    assign out_opcode = nreq_opcode;

endmodule

// File: rtl/evg_checker.sv
module evg_checker #(
    parameter int NUM_ENTRIES = 4,
    parameter int ADDR_W      = 32,
    parameter int DBID_W      = 8,
    parameter int ID_W        = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_start_valid,
    input logic [ADDR_W-1:0] ev_start_addr,
    input logic              ev_start_ready,
    input logic              ev_req_valid,
    input logic [ADDR_W-1:0] ev_req_addr,
    input logic [ID_W-1:0]   ev_req_id,
    input logic              comp_valid,
    input logic [ID_W-1:0]   comp_id,
    input logic              cb_launch_valid,
    input logic [ID_W-1:0]   cb_launch_id,
    input logic              nreq_valid,
    input logic [ADDR_W-1:0] nreq_addr,
    input logic              nreq_grant,
    input logic              proto_err
);

    logic [ADDR_W-1:0] sh_addr [NUM_ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) sh_addr[i] <= '0;
        end else if (ev_req_valid) begin
            sh_addr[ev_req_id] <= ev_req_addr;
        end
    end

    assert_ev_pulse_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_req_valid |-> $past(ev_start_valid && ev_start_ready));

    assert_no_accept_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start_valid && !ev_start_ready) |=> !ev_req_valid);

    assert_new_line_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start_valid && ev_start_ready) ##1
        (nreq_valid && nreq_addr == $past(ev_start_addr)) |-> !nreq_grant);

    assert_launch_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cb_launch_valid |-> ($past(comp_valid) && $past(comp_id) == cb_launch_id));

    assert_pending_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cb_launch_valid && nreq_valid && nreq_addr == sh_addr[cb_launch_id])
        |-> !nreq_grant);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> $past(comp_valid));

endmodule

bind evict_gate_ctrl evg_checker #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ADDR_W      (ADDR_W),
    .DBID_W      (DBID_W),
    .ID_W        (ID_W)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .ev_start_valid  (ev_start_valid),
    .ev_start_addr   (ev_start_addr),
    .ev_start_ready  (ev_start_ready),
    .ev_req_valid    (ev_req_valid),
    .ev_req_addr     (ev_req_addr),
    .ev_req_id       (ev_req_id),
    .comp_valid      (comp_valid),
    .comp_id         (comp_id),
    .cb_launch_valid (cb_launch_valid),
    .cb_launch_id    (cb_launch_id),
    .nreq_valid      (nreq_valid),
    .nreq_addr       (nreq_addr),
    .nreq_grant      (nreq_grant),
    .proto_err       (proto_err)
);

// File: tb/evict_gate_ctrl_tb.sv
`timescale 1ns/1ps
module evict_gate_ctrl_tb_top;

    localparam int N      = 4;
    localparam int ADDR_W = 32;
    localparam int DBID_W = 8;
    localparam int OPC_W  = 6;
    localparam int ID_W   = 2;

    localparam logic [OPC_W-1:0] OP_READ  = 6'h04;
    localparam logic [OPC_W-1:0] OP_WRUNQ = 6'h18;
    localparam logic [OPC_W-1:0] OP_CLEAN = 6'h09;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ev_start_valid = 1'b0;
    logic [ADDR_W-1:0] ev_start_addr = '0;
    logic              ev_start_ready;
    logic              ev_req_valid;
    logic [ADDR_W-1:0] ev_req_addr;
    logic [ID_W-1:0]   ev_req_id;
    logic              comp_valid = 1'b0;
    logic [ID_W-1:0]   comp_id = '0;
    logic [DBID_W-1:0] comp_dbid = '0;
    logic              cb_launch_valid;
    logic [ID_W-1:0]   cb_launch_id;
    logic [DBID_W-1:0] cb_launch_dbid;
    logic              cb_sent_valid = 1'b0;
    logic [ID_W-1:0]   cb_sent_id = '0;
    logic              nreq_valid = 1'b0;
    logic [ADDR_W-1:0] nreq_addr = '0;
    logic [OPC_W-1:0]  nreq_opcode = '0;
    logic              nreq_grant;
    logic              out_valid;
    logic [ADDR_W-1:0] out_addr;
    logic [OPC_W-1:0]  out_opcode;
    logic              proto_err;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    evict_gate_ctrl #(
        .NUM_ENTRIES (N),
        .ADDR_W      (ADDR_W),
        .DBID_W      (DBID_W),
        .OPC_W       (OPC_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .ev_start_valid (ev_start_valid), .ev_start_addr (ev_start_addr),
        .ev_start_ready (ev_start_ready),
        .ev_req_valid (ev_req_valid), .ev_req_addr (ev_req_addr), .ev_req_id (ev_req_id),
        .comp_valid (comp_valid), .comp_id (comp_id), .comp_dbid (comp_dbid),
        .cb_launch_valid (cb_launch_valid), .cb_launch_id (cb_launch_id),
        .cb_launch_dbid (cb_launch_dbid),
        .cb_sent_valid (cb_sent_valid), .cb_sent_id (cb_sent_id),
        .nreq_valid (nreq_valid), .nreq_addr (nreq_addr), .nreq_opcode (nreq_opcode),
        .nreq_grant (nreq_grant), .out_valid (out_valid), .out_addr (out_addr),
        .out_opcode (out_opcode), .proto_err (proto_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic eq(input string req, input string what,
                      input longint act, input longint exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic probe(input logic [ADDR_W-1:0] a, input logic [OPC_W-1:0] op);
        nreq_valid  = 1'b1;
        nreq_addr   = a;
        nreq_opcode = op;
        #1;
    endtask

    task automatic start_ev(input logic [ADDR_W-1:0] a, input int exp_id, input string req);
        ev_start_valid = 1'b1;
        ev_start_addr  = a;
        tick();
        ev_start_valid = 1'b0;
        eq(req, "ev_req_valid", ev_req_valid, 1);
        eq(req, "ev_req_addr", ev_req_addr, a);
        eq(req, "ev_req_id", ev_req_id, exp_id);
    endtask

    task automatic finish_ev(input int id);
        comp_valid = 1'b1; comp_id = ID_W'(id); comp_dbid = 8'h10 + DBID_W'(id);
        tick();
        comp_valid = 1'b0;
        cb_sent_valid = 1'b1; cb_sent_id = ID_W'(id);
        tick();
        cb_sent_valid = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        probe(32'h0000_1000, OP_READ);
        eq("R1", "ev_start_ready", ev_start_ready, 1);
        eq("R1", "proto_err", proto_err, 0);
        eq("R1", "ev_req_valid", ev_req_valid, 0);
        eq("R1", "cb_launch_valid", cb_launch_valid, 0);
        eq("R1", "nreq_grant", nreq_grant, 1);
        nreq_valid = 1'b0;
    endtask

    task automatic t_flow();
        logic [ADDR_W-1:0] a = 32'hA000_0040;
        logic [ADDR_W-1:0] b = 32'hB000_0080;
        start_ev(a, 0, "R2");
        tick();
        eq("R2", "ev_req_valid single pulse", ev_req_valid, 0);
        probe(a, OP_READ);
        eq("R4", "grant on evicting line", nreq_grant, 0);
        eq("R4", "out_valid on evicting line", out_valid, 0);
        probe(b, OP_CLEAN);
        eq("R8", "grant other line", nreq_grant, 1);
        eq("R8", "out_valid", out_valid, 1);
        eq("R8", "out_addr", out_addr, b);
        eq("R8", "out_opcode", out_opcode, OP_CLEAN);
        nreq_valid = 1'b0;
        comp_valid = 1'b1; comp_id = 2'd0; comp_dbid = 8'h5A;
        tick();
        comp_valid = 1'b0;
        eq("R5", "cb_launch_valid", cb_launch_valid, 1);
        eq("R5", "cb_launch_id", cb_launch_id, 0);
        eq("R5", "cb_launch_dbid", cb_launch_dbid, 8'h5A);
        probe(a, OP_WRUNQ);
        eq("R6", "write-unique while pending", nreq_grant, 0);
        tick();
        eq("R5", "launch single pulse", cb_launch_valid, 0);
        probe(a, OP_READ);
        eq("R6", "read while pending", nreq_grant, 0);
        nreq_valid = 1'b0;
        cb_sent_valid = 1'b1; cb_sent_id = 2'd0;
        tick();
        cb_sent_valid = 1'b0;
        probe(a, OP_WRUNQ);
        eq("R7", "blocked in invalid-done cycle", nreq_grant, 0);
        tick();
        eq("R7", "granted after free", nreq_grant, 1);
        nreq_valid = 1'b0;
    endtask

    task automatic t_fill();
        logic [ADDR_W-1:0] e = 32'hE000_0000;
        for (int k = 0; k < N; k++) begin
            start_ev(32'hC000_0000 + ADDR_W'(k * 64), k, "R2");
        end
        eq("R3", "ready when full", ev_start_ready, 0);
        ev_start_valid = 1'b1; ev_start_addr = e;
        tick();
        eq("R3", "no accept when full", ev_req_valid, 0);
        ev_start_valid = 1'b0;
        probe(e, OP_READ);
        eq("R3", "refused offer not tracked", nreq_grant, 1);
        nreq_valid = 1'b0;
        finish_ev(2);
        eq("R11", "ready after free", ev_start_ready, 1);
        start_ev(32'hD000_0000, 2, "R11");
        for (int k = 0; k < N; k++) finish_ev(k);
        eq("R11", "all free ready", ev_start_ready, 1);
    endtask

    task automatic t_stray_sent();
        logic [ADDR_W-1:0] a = 32'hF000_0100;
        start_ev(a, 0, "R10");
        cb_sent_valid = 1'b1; cb_sent_id = 2'd0;
        tick();
        cb_sent_valid = 1'b0;
        tick();
        tick();
        probe(a, OP_READ);
        eq("R10", "still blocked after stray sent", nreq_grant, 0);
        nreq_valid = 1'b0;
        comp_valid = 1'b1; comp_id = 2'd0; comp_dbid = 8'h33;
        tick();
        comp_valid = 1'b0;
        eq("R10", "launch still follows", cb_launch_valid, 1);
        eq("R10", "no error", proto_err, 0);
        cb_sent_valid = 1'b1; cb_sent_id = 2'd0;
        tick();
        cb_sent_valid = 1'b0;
        tick();
    endtask

    task automatic t_bad_comp();
        eq("R9", "err before", proto_err, 0);
        comp_valid = 1'b1; comp_id = 2'd3; comp_dbid = 8'h77;
        tick();
        comp_valid = 1'b0;
        eq("R9", "err set", proto_err, 1);
        eq("R9", "no launch", cb_launch_valid, 0);
        tick();
        tick();
        eq("R9", "err sticky", proto_err, 1);
    endtask

    initial begin
        t_reset();
        t_flow();
        t_fill();
        t_stray_sent();
        t_bad_comp();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule